// File: doc/BRIEF.md
# Parallel 8080-style panel write sequencer

This block pushes one frame of pixel words from a valid/ready stream to a panel that keeps its own frame memory. It drives an active-low chip select, an active-low write strobe and a data bus. Each word follows a phase sequence whose lengths come from a timing word. The frame length is the product of a width and a height input. When the last word has left the bus, a sticky frame-done flag is raised and driven out as an interrupt.

A frame can be started in two ways. In software mode, a rising edge on a command bit starts it, and a tearing-effect (TE) pulse starts one frame if a content update was flagged beforehand. In hardware mode, the synchronised TE input starts frames, either once per TE rising edge or for as long as TE stays high. Any trigger that arrives while a frame is in flight is dropped, not queued.

Top module: `i80_wr_seq`

## Requirements
- R1: While `rst_ni` is low, `lcd_cs_no` and `lcd_wr_no` are 1, and `pix_ready_o` and `frame_irq_o` are 0.
- R2: The timing word `tim_cfg_i` is laid out as follows. Bit 0 is the interface enable. Bits [19:16] hold the CS setup count, [15:12] the WR setup count, [11:8] the WR active count and [7:4] the WR hold count. The word is captured when a frame starts. While bit 0 is 0, every trigger is dropped.
- R3: On the cycle after a frame start, `lcd_cs_no` goes low and stays low with `lcd_wr_no` high for CS setup cycles. Word fetching follows.
- R4: Each word goes through four phases in order. First a fetch phase (at least one cycle, `pix_ready_o` high) ends when `pix_valid_i` is sampled high, and the word is latched. Then `lcd_wr_no` stays high for WR setup cycles. Then it stays low for WR active + 1 cycles, with `lcd_data_o` equal to the latched word. Finally it stays high for WR hold cycles.
- R5: `lcd_cs_no` stays low from the frame start until the last word's hold phase ends. It then goes high.
- R6: A frame carries exactly `frame_w_i * frame_h_i` words. A start with a zero product raises the done flag on the next cycle with no bus activity.
- R7: When `trig_cfg_i[0]` is 1 (software mode), a 0-to-1 change on `trig_cfg_i[1]` starts one frame. Holding bit 1 high starts nothing more.
- R8: When `trig_cfg_i[0]` is 0 (hardware mode), TE may start frames only if `trig_cfg_i[3]` and `trig_cfg_i[4]` are both 1. With `trig_cfg_i[31]` set, each TE rising edge starts one frame. With it clear, any cycle with TE high starts one. TE passes `SYNC_STAGES` flops before use.
- R9: In software mode, a `win_upd_i` pulse sets a pending flag. A TE rising edge consumes that flag and starts one frame. A TE edge with no pending flag starts nothing.
- R10: A trigger that arrives while a frame is in flight is dropped. The block becomes idle on the cycle the done flag is set.
- R11: The done flag `frame_irq_o` is set after the frame ends and holds until `done_clr_i` is high. If set and clear come in the same cycle, set wins.
- R12: While `pix_valid_i` is low during a fetch, the bus waits with `lcd_cs_no` low and `lcd_wr_no` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tim_cfg_i | input | 32 | Timing word and interface enable |
| trig_cfg_i | input | 32 | Trigger mode and command bits |
| te_i | input | 1 | Tearing-effect input from the panel |
| win_upd_i | input | 1 | Content-updated pulse (software mode) |
| frame_w_i | input | DIM_W | Frame width in words |
| frame_h_i | input | DIM_W | Frame height in lines |
| pix_data_i | input | DATA_W | Stream word |
| pix_valid_i | input | 1 | Stream word valid |
| pix_ready_o | output | 1 | Stream word accepted |
| done_clr_i | input | 1 | Clears the done flag |
| lcd_cs_no | output | 1 | Panel chip select, active low |
| lcd_wr_no | output | 1 | Panel write strobe, active low |
| lcd_data_o | output | DATA_W | Panel data bus |
| frame_irq_o | output | 1 | Sticky frame-done flag |

## Verification
The bench builds the block with a 16-bit data bus, 6-bit width and height, and two TE synchroniser stages. With these values, frames of up to a few dozen words stay short enough to run every trigger mode back to back. The 4-bit phase counts can reach both their zero skips and their all-ones maximum. A second TE edge or command edge can be placed well inside a running frame.

// File: rtl/i80_wr_pkg.sv
package i80_wr_pkg;
  localparam int TIM_EN     = 0;
  localparam int TIM_HOLD   = 4;
  localparam int TIM_ACT    = 8;
  localparam int TIM_WRS    = 12;
  localparam int TIM_CSS    = 16;
  localparam int TRG_SWMODE = 0;
  localparam int TRG_SWCMD  = 1;
  localparam int TRG_HWEN   = 3;
  localparam int TRG_HWMASK = 4;
  localparam int TRG_PERTE  = 31;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CSS, PH_FETCH, PH_WRS, PH_ACT, PH_HOLD
  } ph_e;

  typedef struct packed {
    logic [3:0] css;
    logic [3:0] wrs;
    logic [3:0] act;
    logic [3:0] hold;
  } tim_t;

  function automatic tim_t tim_unpack(input logic [31:0] w);
    tim_t t;
    t.css  = w[TIM_CSS+:4];
    t.wrs  = w[TIM_WRS+:4];
    t.act  = w[TIM_ACT+:4];
    t.hold = w[TIM_HOLD+:4];
    return t;
  endfunction
endpackage

// File: rtl/i80_wr_trig.sv
module i80_wr_trig
  import i80_wr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] trig_cfg_i,
  input  logic        te_i,
  input  logic        win_upd_i,
  input  logic        if_en_i,
  input  logic        busy_i,
  output logic        start_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic te_s, te_q, te_rise, cmd_q, cmd_rise, pend_q, consume, req;
  logic cfg_unused;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], te_i};
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= te_i;
    end
  endgenerate

  assign te_s       = sync_q[SYNC_STAGES-1];
  assign te_rise    = te_s & ~te_q;
  assign cmd_rise   = trig_cfg_i[TRG_SWCMD] & ~cmd_q;
  assign cfg_unused = ^{trig_cfg_i[30:5], trig_cfg_i[2]};

  always_comb begin
    consume = 1'b0;
    if (trig_cfg_i[TRG_SWMODE]) begin
      consume = te_rise & pend_q;
      req     = cmd_rise | consume;
    end else begin
      req = trig_cfg_i[TRG_HWEN] & trig_cfg_i[TRG_HWMASK] &
            (trig_cfg_i[TRG_PERTE] ? te_rise : te_s);
    end
  end

  // requests while busy or disabled are dropped, never held
  assign start_o = req & if_en_i & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      te_q   <= 1'b0;
      cmd_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      te_q   <= te_s;
      cmd_q  <= trig_cfg_i[TRG_SWCMD];
      pend_q <= (pend_q & ~consume) | win_upd_i;
    end
  end

  assert_no_start_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !busy_i);
  assert_pend_consumed_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consume && !win_upd_i) |=> !pend_q);
endmodule

// File: rtl/i80_wr_phase.sv
module i80_wr_phase
  import i80_wr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  tim_t              tim_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DATA_W-1:0] pix_data_i,
  input  logic              pix_valid_i,
  output logic              pix_ready_o,
  output logic              cs_no,
  output logic              wr_no,
  output logic [DATA_W-1:0] data_o,
  output logic              busy_o,
  output logic              done_o
);
  ph_e              ph_q, ph_d;
  logic [3:0]       cnt_q, cnt_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  tim_t             tim_q, tim_d;
  logic [DATA_W-1:0] data_q;
  logic             data_ld, wend, done;

  always_comb begin
    ph_d = ph_q; cnt_d = cnt_q; rem_d = rem_q; tim_d = tim_q;
    data_ld = 1'b0; wend = 1'b0; done = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (start_i) begin
        tim_d = tim_i;
        rem_d = len_i;
        if (len_i == '0) done = 1'b1;
        else if (tim_i.css != 4'd0) begin ph_d = PH_CSS; cnt_d = tim_i.css - 4'd1; end
        else ph_d = PH_FETCH;
      end
      PH_CSS: if (cnt_q == 4'd0) ph_d = PH_FETCH; else cnt_d = cnt_q - 4'd1;
      PH_FETCH: if (pix_valid_i) begin
        data_ld = 1'b1;
        if (tim_q.wrs != 4'd0) begin ph_d = PH_WRS; cnt_d = tim_q.wrs - 4'd1; end
        else begin ph_d = PH_ACT; cnt_d = tim_q.act; end
      end
      PH_WRS: if (cnt_q == 4'd0) begin ph_d = PH_ACT; cnt_d = tim_q.act; end
              else cnt_d = cnt_q - 4'd1;
      PH_ACT: if (cnt_q == 4'd0) begin
        if (tim_q.hold != 4'd0) begin ph_d = PH_HOLD; cnt_d = tim_q.hold - 4'd1; end
        else wend = 1'b1;
      end else cnt_d = cnt_q - 4'd1;
      PH_HOLD: if (cnt_q == 4'd0) wend = 1'b1; else cnt_d = cnt_q - 4'd1;
      default: ph_d = PH_IDLE;
    endcase
    if (wend) begin
      if (rem_q > LEN_W'(1)) begin ph_d = PH_FETCH; rem_d = rem_q - LEN_W'(1); end
      else begin ph_d = PH_IDLE; done = 1'b1; end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= PH_IDLE; cnt_q <= '0; rem_q <= '0; tim_q <= '0; data_q <= '0;
    end else begin
      ph_q <= ph_d; cnt_q <= cnt_d; rem_q <= rem_d; tim_q <= tim_d;
      if (data_ld) data_q <= pix_data_i;
    end
  end

  assign busy_o      = ph_q != PH_IDLE;
  assign pix_ready_o = ph_q == PH_FETCH;
  assign cs_no       = ph_q == PH_IDLE;
  assign wr_no       = ph_q != PH_ACT;
  assign data_o      = data_q;
  assign done_o      = done;

  // strobe-width checker
  logic [4:0] act_run_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) act_run_q <= '0;
    else         act_run_q <= (ph_q == PH_ACT) ? act_run_q + 5'd1 : 5'd0;

  assert_act_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ph_q == PH_ACT) && ph_q != PH_ACT) |-> act_run_q == {1'b0, tim_q.act} + 5'd1);
  assert_data_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_ACT && $past(ph_q == PH_ACT)) |-> $stable(data_o));
  assert_rem_live_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q != PH_IDLE) |-> rem_q != '0);
endmodule

// File: rtl/i80_wr_stat.sv
module i80_wr_stat (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_set_i,
  input  logic done_clr_i,
  output logic done_o
);
  logic done_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)         done_q <= 1'b0;
    else if (done_set_i) done_q <= 1'b1;
    else if (done_clr_i) done_q <= 1'b0;
  assign done_o = done_q;

  assert_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_clr_i && !done_set_i) |=> !done_o);
  assert_set_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_set_i |=> done_o);
endmodule

// File: rtl/i80_wr_seq.sv
module i80_wr_seq
  import i80_wr_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int DIM_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       tim_cfg_i,
  input  logic [31:0]       trig_cfg_i,
  input  logic              te_i,
  input  logic              win_upd_i,
  input  logic [DIM_W-1:0]  frame_w_i,
  input  logic [DIM_W-1:0]  frame_h_i,
  input  logic [DATA_W-1:0] pix_data_i,
  input  logic              pix_valid_i,
  output logic              pix_ready_o,
  input  logic              done_clr_i,
  output logic              lcd_cs_no,
  output logic              lcd_wr_no,
  output logic [DATA_W-1:0] lcd_data_o,
  output logic              frame_irq_o
);
  localparam int LEN_W = 2 * DIM_W;

  logic             start, busy, done;
  logic [LEN_W-1:0] len;
  logic             tim_unused;

  assign len        = LEN_W'(frame_w_i) * LEN_W'(frame_h_i);
  assign tim_unused = ^{tim_cfg_i[31:20], tim_cfg_i[3:1]};

  i80_wr_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk_i, .rst_ni, .trig_cfg_i, .te_i, .win_upd_i,
    .if_en_i(tim_cfg_i[TIM_EN]), .busy_i(busy), .start_o(start)
  );

  i80_wr_phase #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_phase (
    .clk_i, .rst_ni, .start_i(start), .tim_i(tim_unpack(tim_cfg_i)), .len_i(len),
    .pix_data_i, .pix_valid_i, .pix_ready_o,
    .cs_no(lcd_cs_no), .wr_no(lcd_wr_no), .data_o(lcd_data_o),
    .busy_o(busy), .done_o(done)
  );

  i80_wr_stat u_stat (
    .clk_i, .rst_ni, .done_set_i(done), .done_clr_i, .done_o(frame_irq_o)
  );

  assert_irq_bus_free_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_irq_o) |-> lcd_cs_no);
  assert_ready_wr_high_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_ready_o |-> (!lcd_cs_no && lcd_wr_no));
  assert_cs_on_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && len != '0) |=> !lcd_cs_no);
endmodule

// File: tb/tb_i80_wr_seq.sv
module tb_i80_wr_seq;
  localparam int DW = 16, DIMW = 6, SYNC = 2;
  localparam logic [31:0] HWB = (32'd1 << 3) | (32'd1 << 4);
  localparam logic [31:0] PER = 32'h8000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] tim_cfg = '0, trig_cfg = '0;
  logic te = 0, win_upd = 0, done_clr = 0, pix_valid = 1;
  logic [DIMW-1:0] fw = '0, fh = '0;
  logic [DW-1:0] pix_data = '0;
  logic pix_ready, cs_n, wr_n, irq;
  logic [DW-1:0] lcd_data;

  i80_wr_seq #(.DATA_W(DW), .DIM_W(DIMW), .SYNC_STAGES(SYNC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tim_cfg_i(tim_cfg), .trig_cfg_i(trig_cfg),
    .te_i(te), .win_upd_i(win_upd), .frame_w_i(fw), .frame_h_i(fh),
    .pix_data_i(pix_data), .pix_valid_i(pix_valid), .pix_ready_o(pix_ready),
    .done_clr_i(done_clr), .lcd_cs_no(cs_n), .lcd_wr_no(wr_n),
    .lcd_data_o(lcd_data), .frame_irq_o(irq)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  int frames = 0, words = 0, low_run = 0, last_low = 0;
  bit prev_cs = 1, prev_wr = 1, bp_mode = 0;
  int vcnt = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: phases 0 idle 1 cs-setup 2 fetch 3 wr-setup 4 strobe 5 hold
  int m_ph = 0, m_left = 0, m_rem = 0, m_cs = 0, m_ws = 0, m_a = 0, m_h = 0;
  logic [DW-1:0] m_data = '0;
  bit m_irq = 0, m_pend = 0, m_c1 = 0, m_tel = 0, done_ev = 0;
  bit m_te[SYNC];

  task automatic m_goto(input int p);
    int q;
    q = p;
    if (q == 1 && m_cs == 0) q = 2;
    if (q == 3 && m_ws == 0) q = 4;
    if (q == 5 && m_h == 0) q = 6;
    if (q == 6) begin
      if (m_rem > 1) begin m_rem--; q = 2; end
      else begin q = 0; done_ev = 1; end
    end
    m_ph = q;
    case (q)
      1: m_left = m_cs;
      3: m_left = m_ws;
      4: m_left = m_a + 1;
      5: m_left = m_h;
      default: m_left = 0;
    endcase
  endtask

  always @(posedge clk or negedge rst_n) begin
    bit te_s, rise, req, cons, st;
    if (!rst_n) begin
      m_ph = 0; m_irq = 0; m_pend = 0; m_c1 = 0; m_tel = 0;
      for (int k = 0; k < SYNC; k++) m_te[k] = 0;
    end else begin
      done_ev = 0;
      te_s = m_te[SYNC-1];
      rise = te_s && !m_tel;
      cons = 0;
      if (trig_cfg[0]) begin
        cons = rise && m_pend;
        req = (trig_cfg[1] && !m_c1) || cons;
      end else
        req = trig_cfg[3] && trig_cfg[4] && (trig_cfg[31] ? rise : te_s);
      st = req && tim_cfg[0] && (m_ph == 0);
      case (m_ph)
        0: if (st) begin
          m_cs = int'(tim_cfg[19:16]); m_ws = int'(tim_cfg[15:12]);
          m_a = int'(tim_cfg[11:8]); m_h = int'(tim_cfg[7:4]);
          m_rem = int'(fw) * int'(fh);
          if (m_rem == 0) done_ev = 1; else m_goto(1);
        end
        2: if (pix_valid) begin m_data = pix_data; m_goto(3); end
        default: if (m_left <= 1) m_goto(m_ph + 1); else m_left--;
      endcase
      if (done_ev) m_irq = 1; else if (done_clr) m_irq = 0;
      m_pend = (m_pend && !cons) || win_upd;
      for (int k = SYNC - 1; k > 0; k--) m_te[k] = m_te[k-1];
      m_te[0] = te;
      m_tel = te_s;
      m_c1 = trig_cfg[1];
    end
  end

  always @(negedge clk) begin
    pix_data <= pix_data + 1'b1;
    vcnt <= vcnt + 1;
    pix_valid <= bp_mode ? (vcnt % 3 != 1) : 1'b1;
  end

  task automatic report;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(0, "watchdog", cyc, 150000);
      report();
      $finish;
    end
    if (rst_n) begin
      check(cs_n == (m_ph == 0), "R5 cs", cs_n, m_ph == 0);
      check(wr_n == (m_ph != 4), "R4 wr", wr_n, m_ph != 4);
      check(pix_ready == (m_ph == 2), "R12 ready", pix_ready, m_ph == 2);
      check(irq == m_irq, "R11 irq", irq, m_irq);
      if (m_ph == 4) check(lcd_data == m_data, "R4 data", lcd_data, m_data);
      if (prev_cs && !cs_n) frames++;
      if (!wr_n) low_run++;
      if (!prev_wr && wr_n) begin words++; last_low = low_run; low_run = 0; end
      prev_cs = cs_n; prev_wr = wr_n;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet;
    int q = 0;
    for (int i = 0; i < 3000 && q < 6; i++) begin
      @(negedge clk);
      if (cs_n) q++; else q = 0;
    end
  endtask

  task automatic set_tim(input int css, input int ws, input int a, input int h, input bit en);
    tim_cfg = {12'd0, 4'(css), 4'(ws), 4'(a), 4'(h), 3'd0, en};
  endtask

  task automatic sw_fire;
    @(negedge clk) trig_cfg = trig_cfg | 32'h2;
    @(negedge clk) trig_cfg = trig_cfg & ~32'h2;
  endtask

  task automatic te_pulse(input int len);
    @(negedge clk) te = 1;
    tick(len);
    te = 0;
  endtask

  task automatic clr_done;
    @(negedge clk) done_clr = 1;
    @(negedge clk) done_clr = 0;
  endtask

  initial begin
    int f0, w0;
    tick(3);
    check(cs_n == 1, "R1 cs reset", cs_n, 1);
    check(wr_n == 1, "R1 wr reset", wr_n, 1);
    check(pix_ready == 0, "R1 ready reset", pix_ready, 0);
    check(irq == 0, "R1 irq reset", irq, 0);
    @(negedge clk) rst_n = 1;
    tick(2);

    // R7 R6 software start, 2x2 frame
    set_tim(0, 0, 1, 0, 1); trig_cfg = 32'h1; fw = 2; fh = 2;
    f0 = frames; w0 = words;
    sw_fire(); quiet();
    check(frames == f0 + 1, "R7 one frame", frames - f0, 1);
    check(words == w0 + 4, "R6 word count", words - w0, 4);
    check(irq == 1, "R11 done set", irq, 1);
    clr_done(); tick(1);
    check(irq == 0, "R11 done cleared", irq, 0);

    // R3 R4 R5 all phases present
    set_tim(2, 1, 3, 2, 1); fw = 3; fh = 1; w0 = words;
    sw_fire(); quiet();
    check(words == w0 + 3, "R5 words in one select", words - w0, 3);
    check(last_low == 4, "R4 strobe width", last_low, 4);
    clr_done();

    // R12 backpressure
    bp_mode = 1; set_tim(0, 0, 0, 0, 1); fw = 5; fh = 1; w0 = words;
    sw_fire(); quiet(); bp_mode = 0;
    check(words == w0 + 5, "R12 words under stall", words - w0, 5);
    clr_done();

    // R2 interface disabled
    set_tim(0, 0, 1, 0, 0); f0 = frames;
    sw_fire(); tick(20);
    check(frames == f0, "R2 disabled ignores trigger", frames - f0, 0);

    // R4 maximum counts
    set_tim(15, 15, 15, 15, 1); fw = 1; fh = 1;
    sw_fire(); quiet();
    check(last_low == 16, "R4 max strobe width", last_low, 16);
    clr_done();

    // R7 level held: one frame only
    set_tim(0, 0, 1, 0, 1); f0 = frames;
    @(negedge clk) trig_cfg = 32'h3; tick(80);
    trig_cfg = 32'h1; quiet();
    check(frames == f0 + 1, "R7 held command single frame", frames - f0, 1);
    clr_done();

    // R8 R10 hardware per-edge, second edge while busy
    trig_cfg = HWB | PER; set_tim(0, 0, 3, 0, 1); fw = 4; fh = 2; f0 = frames;
    te_pulse(3); tick(8); te_pulse(3); quiet();
    check(frames == f0 + 1, "R10 edge during frame dropped", frames - f0, 1);
    te_pulse(3); quiet();
    check(frames == f0 + 2, "R8 edge starts frame", frames - f0, 2);
    clr_done();

    // R8 level mode
    trig_cfg = HWB; fw = 1; fh = 1; f0 = frames;
    @(negedge clk) te = 1; tick(60); te = 0; quiet();
    check(frames >= f0 + 2, "R8 level restarts", frames - f0, 2);
    clr_done();

    // R8 mask clear
    trig_cfg = (32'd1 << 3) | PER; f0 = frames;
    te_pulse(3); tick(20);
    check(frames == f0, "R8 masked TE ignored", frames - f0, 0);

    // R9 software mode TE with and without pending update
    trig_cfg = 32'h1; f0 = frames;
    te_pulse(3); tick(15);
    check(frames == f0, "R9 TE without update", frames - f0, 0);
    @(negedge clk) win_upd = 1;
    @(negedge clk) win_upd = 0;
    te_pulse(3); quiet();
    check(frames == f0 + 1, "R9 update consumed", frames - f0, 1);
    te_pulse(3); tick(15);
    check(frames == f0 + 1, "R9 no second frame", frames - f0, 1);
    clr_done();

    // R6 zero length
    fw = 0; fh = 3; f0 = frames;
    sw_fire(); tick(10);
    check(frames == f0, "R6 zero length no bus", frames - f0, 0);
    check(irq == 1, "R6 zero length done", irq, 1);
    clr_done();

    // R10 software command while busy
    set_tim(0, 0, 3, 0, 1); fw = 4; fh = 2; f0 = frames;
    sw_fire(); tick(5); sw_fire(); quiet();
    check(frames == f0 + 1, "R10 command during frame dropped", frames - f0, 1);
    clr_done(); tick(4);

    report();
    $finish;
  end
endmodule